// File: doc/BRIEF.md
# Adaptive Synapse Weight Updater

This block is the digital part of one synapse cell in an on-chip learning array for stochastic or deterministic-annealing feedback networks. It keeps a signed weight in sign-magnitude form, latches the product of the two binary neuron states it connects at two instants of each pattern presentation, and on an adjust strobe moves the weight by one unit. The step direction follows the sign of the clamped-phase correlation minus the free-phase correlation. The weight can also be loaded from outside. Each of the two conductance directions has its own enable, so the connection can be made one-way.

The sequencer strobes `free_cap` when the free-running phase settles and `clamp_cap` when the clamped phase settles. It then pulses `adjust` once per pattern. The two gated weight outputs feed the analog multipliers of the two directions. Those multipliers are outside this block.

Top module: `adaptive_synapse`

## Requirements
- R1: After reset the weight is +0 (`w_sign`=0, `w_mag`=0). Both correlation latches hold -1, so an adjust that follows reset with no capture leaves the weight at +0.
- R2: A neuron state bit of 1 means +1 and 0 means -1. The correlation is their product, +1 exactly when `pre_state` equals `post_state`. `free_cap` stores it in the free latch and `clamp_cap` stores it in the clamped latch, one clock edge later. A capture alone does not change the weight.
- R3: On `adjust`, if the clamped latch holds +1 and the free latch holds -1, the weight rises by one unit after the same clock edge.
- R4: On `adjust`, if the clamped latch holds -1 and the free latch holds +1, the weight falls by one unit after the same clock edge.
- R5: On `adjust` with equal latched correlations, the weight is unchanged.
- R6: The weight saturates. A rise at +15 or a fall at -15 leaves it unchanged, and one adjust changes the signed value by at most one.
- R7: A magnitude of zero always carries sign 0, including when a step crosses zero in either direction.
- R8: With `wr_en` high, the weight takes `wr_sign`/`wr_mag` after the clock edge. A write of sign 1 with magnitude 0 stores +0.
- R9: When `wr_en` and `adjust` are high in the same cycle, the write wins.
- R10: `fwd_sign`/`fwd_mag` equal the stored weight when `fwd_en` is 1 and are 0/0 when it is 0. `rev_sign`/`rev_mag` work the same way with `rev_en`. These outputs follow the enables without a clock edge.
- R11: Without `adjust` or `wr_en`, the stored weight holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pre_state | input | 1 | Presynaptic neuron state (1 = +1, 0 = -1) |
| post_state | input | 1 | Postsynaptic neuron state (1 = +1, 0 = -1) |
| free_cap | input | 1 | Capture correlation at end of free phase |
| clamp_cap | input | 1 | Capture correlation at end of clamped phase |
| adjust | input | 1 | Apply one learning step |
| wr_en | input | 1 | Load weight from write port |
| wr_sign | input | 1 | Sign of loaded weight (1 = negative) |
| wr_mag | input | MAG_W | Magnitude of loaded weight |
| fwd_en | input | 1 | Enable forward conductance direction |
| rev_en | input | 1 | Enable reverse conductance direction |
| w_sign | output | 1 | Stored weight sign |
| w_mag | output | MAG_W | Stored weight magnitude |
| fwd_sign | output | 1 | Forward-direction weight sign after gating |
| fwd_mag | output | MAG_W | Forward-direction weight magnitude after gating |
| rev_sign | output | 1 | Reverse-direction weight sign after gating |
| rev_mag | output | MAG_W | Reverse-direction weight magnitude after gating |

## Verification
Captures, adjusts and writes are all sampled on one rising edge, and their effect shows on the weight outputs right after that edge. An adjust uses the latch values from before any capture in the same cycle. The direction gating is combinational, so it reflects the enables within the same cycle. The driver applies each operation shortly after a falling edge and pushes its expected weight after the rising edge. The monitor pops and compares that item just after the next falling edge, before the driver changes any input.

// File: rtl/syn_pkg.sv
package syn_pkg;

    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } step_e;

    // correlation bit: 1 means +1, 0 means -1
    typedef struct packed {
        logic free_c;
        logic clamp_c;
    } corr_t;

endpackage

// File: rtl/syn_corr_latch.sv
module syn_corr_latch
    import syn_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  pre_state,
    input  logic  post_state,
    input  logic  free_cap,
    input  logic  clamp_cap,
    output step_e step
);

    corr_t corr_d, corr_q;
    logic  prod;

    always_comb begin
        prod   = ~(pre_state ^ post_state);
        corr_d = corr_q;
        if (free_cap)  corr_d.free_c  = prod;
        if (clamp_cap) corr_d.clamp_c = prod;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) corr_q <= '0;
        else        corr_q <= corr_d;
    end

    always_comb begin
        if (corr_q.clamp_c == corr_q.free_c) step = STEP_HOLD;
        else if (corr_q.clamp_c)             step = STEP_UP;
        else                                 step = STEP_DOWN;
    end

    AST_CAPTURE_HOLDS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!free_cap && !clamp_cap) |=> $stable(step)) else $error("latch moved"); // R2

endmodule

// File: rtl/syn_weight_step.sv
module syn_weight_step
    import syn_pkg::*;
#(
    parameter int MAG_W = 4
) (
    input  logic             sign_i,
    input  logic [MAG_W-1:0] mag_i,
    input  step_e            step,
    output logic             sign_o,
    output logic [MAG_W-1:0] mag_o
);

    localparam logic [MAG_W-1:0] MAG_MAX = {MAG_W{1'b1}};
    localparam logic [MAG_W-1:0] MAG_ONE = {{(MAG_W-1){1'b0}}, 1'b1};

    logic grow;    // step moves away from zero
    logic at_zero;

    always_comb begin
        at_zero = (mag_i == '0);
        grow    = (step == STEP_UP   && !sign_i) ||
                  (step == STEP_DOWN &&  sign_i);
        sign_o  = sign_i;
        mag_o   = mag_i;
        case (step)
            STEP_HOLD: begin
                sign_o = sign_i;
                mag_o  = mag_i;
            end
            default: begin
                if (at_zero) begin
                    sign_o = (step == STEP_DOWN);
                    mag_o  = MAG_ONE;
                end else if (grow) begin
                    if (mag_i != MAG_MAX) mag_o = mag_i + MAG_ONE;
                end else begin
                    mag_o = mag_i - MAG_ONE;
                    if (mag_o == '0) sign_o = 1'b0;
                end
            end
        endcase
    end

endmodule

// File: rtl/syn_dir_gate.sv
module syn_dir_gate #(
    parameter int MAG_W = 4
) (
    input  logic             en,
    input  logic             sign_i,
    input  logic [MAG_W-1:0] mag_i,
    output logic             sign_o,
    output logic [MAG_W-1:0] mag_o
);

    always_comb begin
        sign_o = en & sign_i;
        mag_o  = en ? mag_i : '0;
    end

endmodule

// File: rtl/adaptive_synapse.sv
module adaptive_synapse
    import syn_pkg::*;
#(
    parameter int MAG_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pre_state,
    input  logic             post_state,
    input  logic             free_cap,
    input  logic             clamp_cap,
    input  logic             adjust,
    input  logic             wr_en,
    input  logic             wr_sign,
    input  logic [MAG_W-1:0] wr_mag,
    input  logic             fwd_en,
    input  logic             rev_en,
    output logic             w_sign,
    output logic [MAG_W-1:0] w_mag,
    output logic             fwd_sign,
    output logic [MAG_W-1:0] fwd_mag,
    output logic             rev_sign,
    output logic [MAG_W-1:0] rev_mag
);

    localparam int N_DIR  = 2;
    localparam int MAX_SV = (1 << MAG_W) - 1;

    typedef struct packed {
        logic             sign;
        logic [MAG_W-1:0] mag;
    } wt_t;

    wt_t   w_d, w_q, stepped;
    step_e step;

    syn_corr_latch u_corr (
        .clk        (clk),
        .rst_n      (rst_n),
        .pre_state  (pre_state),
        .post_state (post_state),
        .free_cap   (free_cap),
        .clamp_cap  (clamp_cap),
        .step       (step)
    );

    syn_weight_step #(.MAG_W(MAG_W)) u_step (
        .sign_i (w_q.sign),
        .mag_i  (w_q.mag),
        .step   (step),
        .sign_o (stepped.sign),
        .mag_o  (stepped.mag)
    );

    always_comb begin
        w_d = w_q;
        if (wr_en) begin
            w_d.sign = wr_sign && (wr_mag != '0);
            w_d.mag  = wr_mag;
        end else if (adjust) begin
            w_d = stepped;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) w_q <= '0;
        else        w_q <= w_d;
    end

    assign w_sign = w_q.sign;
    assign w_mag  = w_q.mag;

    // direction gating: index 0 forward, index 1 reverse
    logic [N_DIR-1:0]             dir_en;
    logic [N_DIR-1:0]             dir_sign;
    logic [N_DIR-1:0][MAG_W-1:0]  dir_mag;

    assign dir_en = {rev_en, fwd_en};

    for (genvar g = 0; g < N_DIR; g++) begin : g_dir
        syn_dir_gate #(.MAG_W(MAG_W)) u_gate (
            .en     (dir_en[g]),
            .sign_i (w_q.sign),
            .mag_i  (w_q.mag),
            .sign_o (dir_sign[g]),
            .mag_o  (dir_mag[g])
        );
    end

    assign fwd_sign = dir_sign[0];
    assign fwd_mag  = dir_mag[0];
    assign rev_sign = dir_sign[1];
    assign rev_mag  = dir_mag[1];

    int sv_q;
    always_comb sv_q = w_q.sign ? -int'(w_q.mag) : int'(w_q.mag);

    AST_NO_NEG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !(w_q.sign && w_q.mag == '0)) else $error("negative zero"); // R7
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!adjust && !wr_en) |=> $stable(w_q)) else $error("weight drift"); // R11
    AST_STEP_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (adjust && !wr_en) |=> ((sv_q - $past(sv_q) <= 1) && (sv_q - $past(sv_q) >= -1)
                                && sv_q <= MAX_SV && sv_q >= -MAX_SV))
        else $error("step too large"); // R6
    AST_HOLD_ON_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
        (adjust && !wr_en && step == STEP_HOLD) |=> $stable(w_q))
        else $error("moved on equal"); // R5
    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (w_q.mag == $past(wr_mag))) else $error("write lost"); // R9

endmodule

// File: tb/adaptive_synapse_test.sv
module adaptive_synapse_test;

    localparam int MAG_W = 4;
    localparam int WMAX  = (1 << MAG_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pre_state = 0, post_state = 0, free_cap = 0, clamp_cap = 0;
    logic adjust = 0, wr_en = 0, wr_sign = 0;
    logic [MAG_W-1:0] wr_mag = '0;
    logic fwd_en = 1, rev_en = 1;
    logic w_sign, fwd_sign, rev_sign;
    logic [MAG_W-1:0] w_mag, fwd_mag, rev_mag;

    always #4 clk = ~clk;   // 125 MHz

    adaptive_synapse #(.MAG_W(MAG_W)) uut (.*);

    typedef struct {
        int    w;
        bit    fe;
        bit    re;
        string tag;
    } exp_t;

    exp_t q[$];
    int checks = 0, fails = 0;
    int wmodel = 0, free_m = -1, clamp_m = -1;
    bit en_f = 1, en_r = 1;
    bit done = 0;

    task automatic check_out(input int w, input bit fe, input bit re, input string tag);
        logic s; logic [MAG_W-1:0] m;
        s = (w < 0);
        m = MAG_W'(w < 0 ? -w : w);
        checks++;
        if (w_sign !== s || w_mag !== m ||
            fwd_sign !== (fe & s) || fwd_mag !== (fe ? m : '0) ||
            rev_sign !== (re & s) || rev_mag !== (re ? m : '0)) begin
            fails++;
            $display("FAIL %s: got w=%b/%0d fwd=%b/%0d rev=%b/%0d expected w=%b/%0d fwd_en=%b rev_en=%b",
                     tag, w_sign, w_mag, fwd_sign, fwd_mag, rev_sign, rev_mag, s, m, fe, re);
        end
    endtask

    task automatic op(input bit adj, input bit wr, input bit ws, input int wm,
                      input bit fc, input bit cc, input bit pr, input bit po,
                      input string tag);
        exp_t e;
        @(negedge clk); #2;
        adjust = adj; wr_en = wr; wr_sign = ws; wr_mag = MAG_W'(wm);
        free_cap = fc; clamp_cap = cc; pre_state = pr; post_state = po;
        fwd_en = en_f; rev_en = en_r;
        @(posedge clk);
        if (wr) wmodel = ws ? -wm : wm;
        else if (adj) begin
            if (clamp_m > free_m && wmodel < WMAX) wmodel++;
            else if (clamp_m < free_m && wmodel > -WMAX) wmodel--;
        end
        if (fc) free_m  = (pr == po) ? 1 : -1;
        if (cc) clamp_m = (pr == po) ? 1 : -1;
        #1;
        adjust = 0; wr_en = 0; free_cap = 0; clamp_cap = 0;
        e.w = wmodel; e.fe = en_f; e.re = en_r; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic cap(input bit fp, input bit cp, input bit pr, input bit po, input string tag);
        op(0, 0, 0, 0, fp, cp, pr, po, tag);
    endtask
    task automatic adj(input string tag);
        op(1, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask
    task automatic wr(input bit s, input int m, input string tag);
        op(0, 1, s, m, 0, 0, 0, 0, tag);
    endtask

    // monitor: compare one expected item just after each falling edge
    initial begin
        exp_t e;
        forever begin
            @(negedge clk); #1;
            if (q.size() > 0) begin
                e = q.pop_front();
                check_out(e.w, e.fe, e.re, e.tag);
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1 check_out(0, 1, 1, "R1 reset state");
        adj("R1 adjust after reset holds +0");
        // free=-1 (1,0), clamp=+1 (1,1): rising; capture alone no change
        cap(1, 0, 1, 0, "R2 free capture no weight change");
        cap(0, 1, 1, 1, "R2 clamp capture no weight change");
        adj("R3 rise to +1");
        adj("R3 rise to +2");
        for (int i = 0; i < 16; i++) adj("R6 rise saturates at +15");
        wr(1, 14, "R8 write -14");
        // free=+1 (0,0), clamp=-1 (0,1): falling
        cap(1, 0, 0, 0, "R2 free capture +1");
        cap(0, 1, 0, 1, "R2 clamp capture -1");
        adj("R4 fall to -15");
        adj("R6 fall saturates at -15");
        wr(0, 2, "R8 write +2");
        adj("R4 fall to +1");
        adj("R7 fall to +0");
        adj("R7 fall to -1");
        // swap to rising: clamp=+1
        cap(0, 1, 1, 1, "R2 clamp capture +1");
        cap(1, 0, 0, 1, "R2 free capture -1");
        adj("R7 rise from -1 to +0");
        adj("R3 rise from +0 to +1");
        wr(1, 0, "R8 negative zero write stored as +0");
        wr(0, 9, "R8 write +9");
        op(1, 1, 1, 5, 0, 0, 0, 0, "R9 write beats adjust");
        // equal correlations: both +1
        cap(1, 1, 1, 1, "R2 both capture +1");
        adj("R5 equal correlations hold");
        cap(1, 1, 0, 1, "R2 both capture -1");
        adj("R5 equal -1 correlations hold");
        en_f = 0;
        cap(0, 0, 0, 0, "R10 forward disabled");
        en_f = 1; en_r = 0;
        cap(0, 0, 1, 0, "R10 reverse disabled");
        en_r = 1;
        cap(0, 0, 0, 0, "R10 both enabled");
        for (int i = 0; i < 3; i++) cap(0, 0, 1, 1, "R11 idle holds");
        repeat (3) @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule